// File: doc/BRIEF.md
# SPI Shift Engine with Variable Character Length

This block moves one character of 1 to 8 bits over a four-wire serial link, as either the clock-driving end (master) or the clock-following end (slave). One shift register holds the outgoing character before a transfer and the incoming character after it. A read of the data port always shows that register as it is at that moment. In master mode a write to the data port starts a transfer at once, and a 16-bit reload divider paces the bit clock. In slave mode the same write only preloads the register. The transfer then runs on the external serial clock and select.

Data moves MSB first. The serial clock idles low, the outgoing bit changes after a falling edge, and the incoming bit is taken on a rising edge. A short character is sent from the top bits of the register and lands in its bottom bits. When the engine is disabled, the divider can run as a standalone timer that pulses an interrupt each time it expires.

Top module: `spi_xfer_engine`

## Requirements
- R1: In master mode (`cfg_en`=1, `cfg_master`=1), a `data_wr` while idle loads `wr_data` and starts a transfer. `ss_n_o` is low while it runs. The top N bits of the written byte appear on `sdo_o`, MSB first, each one stable while `sck_o` is high. `sck_o` is low whenever no transfer is busy.
- R2: After an N-bit transfer, `rd_data` equals the written byte shifted left by N with the N received bits in bits [N-1:0], oldest received bit highest.
- R3: With divider value D (D=0 counts as 1), each half period of `sck_o` lasts D clock cycles. `st_done` is set at the clock edge 2·N·D cycles after the edge that took the write.
- R4: A `data_wr` while `st_busy`=1 leaves the register unchanged and sets `st_ovr`. `st_ovr` stays set until `stat_wr` occurs with `wr_data[0]`=1. A `stat_wr` with `wr_data[0]`=0 leaves it set.
- R5: `st_done` sets when the last bit of a character has shifted in and clears on the edge after `data_rd`.
- R6: In slave mode (`cfg_en`=1, `cfg_master`=0), `data_wr` only preloads the register and `sck_o` stays low. With `ss_n_i` low, the engine samples `sdi_i` on rising `sck_i` edges, drives `sdo_o` from the register's top bit, and moves to the next bit after falling `sck_i` edges.
- R7: In slave mode, `ss_n_i` going high mid-character ends the transfer without setting `st_done`, clears `st_busy`, and restarts the bit count at zero.
- R8: With `cfg_en`=0 and `tmr_irq_en`=1, `tmr_irq` pulses every max(D,1) cycles. When either condition is false, it never pulses.
- R9: After reset `sck_o`=0, `ss_n_o`=1, and `st_busy`, `st_done`, `st_ovr` and `tmr_irq` are 0.
- R10: `cfg_len_m1` = k selects a character length of k+1 bits (0 gives 1 bit, 7 gives 8 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Engine enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_len_m1 | input | 3 | Character length minus one |
| tmr_irq_en | input | 1 | Timer interrupt enable (used while disabled) |
| wr_data | input | 8 | Write data for data, divider and status strobes |
| data_wr | input | 1 | Write strobe for the data register |
| data_rd | input | 1 | Read strobe for the data register (clears done) |
| div_lo_wr | input | 1 | Load divider low byte from wr_data |
| div_hi_wr | input | 1 | Load divider high byte from wr_data |
| stat_wr | input | 1 | Status write; wr_data[0]=1 clears overrun |
| rd_data | output | 8 | Live shift register contents |
| st_busy | output | 1 | Character in progress |
| st_done | output | 1 | Character complete flag |
| st_ovr | output | 1 | Sticky overrun flag |
| tmr_irq | output | 1 | Timer interrupt pulse |
| sck_o | output | 1 | Serial clock driven in master mode |
| ss_n_o | output | 1 | Select driven low during a master transfer |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Select from an external master, active low |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
Master transfers run over lengths 1, 3, 4, 5, 7 and 8 with divider values 0 to 3, using loopback, all-zero and all-one serial input. Loopback shows whether the received bits sit at the bottom of the register and whether the transmit bits come from the top. Constant inputs show whether the register shifts left or right, and the cycle counts show the divider period and the zero-as-one case. Slave transfers at full and half length compare the preload against the bits seen on the wire. An aborted slave character, followed by a fresh one, shows whether the bit count restarts. Timer runs with a small and a two-byte divider, and with each enable condition off, isolate the standalone interrupt.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // one clock-cycle strobes for the two serial clock edges
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload,
  input  logic             run,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, reload_eff;

  always_comb begin
    reload_eff = (reload == '0) ? DIV_W'(1) : reload;
    tick       = run && (cnt_q <= DIV_W'(1));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = reload_eff;
    else if (run) cnt_d = tick ? reload_eff : cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_eng_sync.sv
module spi_eng_sync
  import spi_eng_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_i,
  input  logic     ss_n_i,
  input  logic     sdi_i,
  output sck_evt_t evt,
  output logic     ss_act,
  output logic     sdi_s
);
  logic [2:0] sck_sh;
  logic [1:0] ss_sh, sdi_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh <= '0;
      ss_sh  <= 2'b11;
      sdi_sh <= '0;
    end else begin
      sck_sh <= {sck_sh[1:0], sck_i};
      ss_sh  <= {ss_sh[0], ss_n_i};
      sdi_sh <= {sdi_sh[0], sdi_i};
    end
  end

  always_comb begin
    evt.rise = sck_sh[1] & ~sck_sh[2];
    evt.fall = ~sck_sh[1] & sck_sh[2];
    ss_act   = ~ss_sh[1];
    sdi_s    = sdi_sh[1];
  end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              start,
  input  logic [DATA_W-1:0] ld_data,
  input  sck_evt_t          evt,
  input  logic              abort,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              sdi,
  output logic [DATA_W-1:0] sr,
  output logic              active,
  output logic              done_pulse
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d, cap_q, cap_d;

  always_comb begin
    sr_d       = sr_q;
    cnt_d      = cnt_q;
    act_d      = act_q;
    cap_d      = cap_q;
    done_pulse = 1'b0;
    if (start) begin
      sr_d  = ld_data;
      act_d = 1'b1;
      cnt_d = '0;
    end else begin
      if (load) sr_d = ld_data;
      if (abort) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        if (evt.rise) begin
          cap_d = sdi;
          act_d = 1'b1;
        end
        if (evt.fall && act_q) begin
          sr_d = {sr_q[DATA_W-2:0], cap_q};
          if (cnt_q == len_m1) begin
            act_d      = 1'b0;
            cnt_d      = '0;
            done_pulse = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
      cap_q <= cap_d;
    end
  end

  assign sr     = sr_q;
  assign active = act_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int  DATA_W = 8,
  parameter int  DIV_W  = 16,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int HI_W   = DIV_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_master,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              tmr_irq_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              div_lo_wr,
  input  logic              div_hi_wr,
  input  logic              stat_wr,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_busy,
  output logic              st_done,
  output logic              st_ovr,
  output logic              tmr_irq,
  output logic              sck_o,
  output logic              ss_n_o,
  input  logic              sck_i,
  input  logic              ss_n_i,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic [DIV_W-1:0]  div_q, div_d;
  logic              sck_q, sck_d, done_q, done_d, ovr_q, ovr_d, irq_q, irq_d;
  logic              m_mode, s_mode, tmr_mode, active, tick, m_tick;
  logic              start, load, abort, run, done_pulse, ss_act, sdi_s, sdi_sel;
  logic [DATA_W-1:0] sr;
  sck_evt_t          evt_s, evt_sel;

  always_comb begin
    m_mode   = cfg_en & cfg_master;
    s_mode   = cfg_en & ~cfg_master;
    tmr_mode = ~cfg_en & tmr_irq_en;
    start    = data_wr & ~active & m_mode;
    load     = data_wr & ~active & ~m_mode;
    abort    = ~cfg_en | (s_mode & ~ss_act);
    run      = (m_mode & active) | tmr_mode;
    m_tick   = tick & m_mode & active;
    if (m_mode) begin
      evt_sel.rise = m_tick & ~sck_q;
      evt_sel.fall = m_tick & sck_q;
    end else if (s_mode & ss_act) begin
      evt_sel = evt_s;
    end else begin
      evt_sel = '0;
    end
    sdi_sel = m_mode ? sdi_i : sdi_s;
  end

  spi_eng_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .reload(div_q), .run(run),
    .restart(start), .tick(tick)
  );

  spi_eng_sync sync_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi_i(sdi_i),
    .evt(evt_s), .ss_act(ss_act), .sdi_s(sdi_s)
  );

  spi_eng_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start), .ld_data(wr_data),
    .evt(evt_sel), .abort(abort), .len_m1(cfg_len_m1), .sdi(sdi_sel),
    .sr(sr), .active(active), .done_pulse(done_pulse)
  );

  always_comb begin
    div_d = div_q;
    if (div_lo_wr) div_d[DATA_W-1:0]     = wr_data;
    if (div_hi_wr) div_d[DIV_W-1:DATA_W] = wr_data[HI_W-1:0];

    sck_d = sck_q;
    if (!m_mode || start) sck_d = 1'b0;
    else if (m_tick)      sck_d = ~sck_q;

    done_d = done_q;
    if (done_pulse)   done_d = 1'b1;
    else if (data_rd) done_d = 1'b0;

    ovr_d = ovr_q;
    if (data_wr && active)          ovr_d = 1'b1;
    else if (stat_wr && wr_data[0]) ovr_d = 1'b0;

    irq_d = tick & tmr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
      irq_q  <= irq_d;
    end
  end

  assign rd_data = sr;
  assign st_busy = active;
  assign st_done = done_q;
  assign st_ovr  = ovr_q;
  assign tmr_irq = irq_q;
  assign sck_o   = sck_q;
  assign ss_n_o  = ~(m_mode & active);
  assign sdo_o   = sr[DATA_W-1];
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              tmr_irq_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              data_wr,
  input logic              data_rd,
  input logic              stat_wr,
  input logic              st_busy,
  input logic              st_done,
  input logic              st_ovr,
  input logic              tmr_irq,
  input logic              sck_o,
  input logic              sdo_o
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy |-> !sck_o);  // R1
  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(sdo_o));  // R1
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && st_busy) |=> st_ovr);  // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovr && !(stat_wr && wr_data[0])) |=> st_ovr);  // R4
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && data_rd && !st_busy) |=> !st_done);  // R5
  AST_IRQ_TMR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> $past(!cfg_en && tmr_irq_en));  // R8
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .tmr_irq_en(tmr_irq_en),
  .wr_data(wr_data), .data_wr(data_wr), .data_rd(data_rd), .stat_wr(stat_wr),
  .st_busy(st_busy), .st_done(st_done), .st_ovr(st_ovr), .tmr_irq(tmr_irq),
  .sck_o(sck_o), .sdo_o(sdo_o)
);

// File: tb/spi_xfer_engine_tb.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
  logic       clk, rst_n;
  logic       cfg_en, cfg_master, tmr_irq_en;
  logic [2:0] cfg_len_m1;
  logic [7:0] wr_data, rd_data;
  logic       data_wr, data_rd, div_lo_wr, div_hi_wr, stat_wr;
  logic       st_busy, st_done, st_ovr, tmr_irq, sck_o, ss_n_o;
  logic       sck_i, ss_n_i, sdo_o, sdi_i, slv_sdi;
  int         miso_sel;
  int         n_chk, n_fail;
  bit         finished;

  spi_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_len_m1(cfg_len_m1), .tmr_irq_en(tmr_irq_en), .wr_data(wr_data),
    .data_wr(data_wr), .data_rd(data_rd), .div_lo_wr(div_lo_wr),
    .div_hi_wr(div_hi_wr), .stat_wr(stat_wr), .rd_data(rd_data),
    .st_busy(st_busy), .st_done(st_done), .st_ovr(st_ovr), .tmr_irq(tmr_irq),
    .sck_o(sck_o), .ss_n_o(ss_n_o), .sck_i(sck_i), .ss_n_i(ss_n_i),
    .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    case (miso_sel)
      0:       sdi_i = sdo_o;
      1:       sdi_i = 1'b0;
      2:       sdi_i = 1'b1;
      default: sdi_i = slv_sdi;
    endcase
  end

  // vector: len_m1[36:34] div[33:18] data[17:10] miso[9:8] expected rd[7:0]
  localparam logic [36:0] VEC [0:5] = '{
    {3'd7, 16'd1, 8'hA5, 2'd0, 8'hA5},
    {3'd3, 16'd2, 8'hC3, 2'd0, 8'h3C},
    {3'd0, 16'd0, 8'h80, 2'd2, 8'h01},
    {3'd2, 16'd3, 8'hFF, 2'd1, 8'hF8},
    {3'd4, 16'd1, 8'h5A, 2'd0, 8'h4B},
    {3'd6, 16'd2, 8'h96, 2'd0, 8'h4B}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [15:0] v);
    @(negedge clk); wr_data = v[7:0]; div_lo_wr = 1'b1;
    @(negedge clk); div_lo_wr = 1'b0; wr_data = v[15:8]; div_hi_wr = 1'b1;
    @(negedge clk); div_hi_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); wr_data = v; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); wr_data = v; stat_wr = 1'b1;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic slv_bit(input logic b, output logic o);
    slv_sdi = b;
    repeat (8) @(negedge clk);
    o = sdo_o;
    sck_i = 1'b1;
    repeat (8) @(negedge clk);
    sck_i = 1'b0;
  endtask

  task automatic run_master(input logic [36:0] v);
    int       n, d, cyc, txv, txe;
    logic     prev;
    bit       ssbad;
    n = int'(v[36:34]) + 1;
    d = (v[33:18] == 0) ? 1 : int'(v[33:18]);
    cfg_en = 1'b0;
    wr_div(v[33:18]);
    cfg_en = 1'b1; cfg_master = 1'b1; cfg_len_m1 = v[36:34]; miso_sel = int'(v[9:8]);
    @(negedge clk); wr_data = v[17:10]; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
    cyc = 1; prev = sck_o; txv = 0; ssbad = 0;
    while (!st_done && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (sck_o && !prev) begin
        txv = (txv << 1) | int'(sdo_o);
        if (ss_n_o) ssbad = 1;
      end
      prev = sck_o;
    end
    txe = int'(v[17:10]) >> (8 - n);
    check(txv == txe, "R1 master sdo bits MSB first", txv, txe);
    check(!ssbad, "R1 ss_n_o low during transfer", int'(ssbad), 0);
    check(rd_data == v[7:0], "R2/R10 received placement", int'(rd_data), int'(v[7:0]));
    check(cyc == 2 * n * d + 1, "R3 transfer length in cycles", cyc, 2 * n * d + 1);
    rd_pulse();
    check(!st_done, "R5 done cleared by read", int'(st_done), 0);
  endtask

  task automatic measure_irq(output int gap);
    int w;
    w = 0;
    while (!tmr_irq && w < 2000) begin @(negedge clk); w++; end
    @(negedge clk); gap = 1;
    while (!tmr_irq && gap < 2000) begin @(negedge clk); gap++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..R10 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx;
    logic       o;
    int         gap, cnt;
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_master = 1'b0; tmr_irq_en = 1'b0;
    cfg_len_m1 = 3'd7; wr_data = '0; data_wr = 0; data_rd = 0;
    div_lo_wr = 0; div_hi_wr = 0; stat_wr = 0;
    sck_i = 1'b0; ss_n_i = 1'b1; slv_sdi = 1'b0; miso_sel = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sck_o && ss_n_o && !st_busy && !st_done && !st_ovr && !tmr_irq,
          "R9 reset state",
          {sck_o, ss_n_o, st_busy, st_done, st_ovr, tmr_irq}, 6'b010000);

    // main function: table of master transfers
    for (int i = 0; i < 6; i++) run_master(VEC[i]);

    // R4: overrun during a master transfer
    cfg_en = 1'b0; wr_div(16'd2);
    cfg_en = 1'b1; cfg_master = 1'b1; cfg_len_m1 = 3'd7; miso_sel = 0;
    wr_dat(8'h3C);
    repeat (4) @(negedge clk);
    wr_dat(8'h00);
    check(st_ovr, "R4 overrun set by busy write", int'(st_ovr), 1);
    cnt = 0;
    while (!st_done && cnt < 200) begin @(negedge clk); cnt++; end
    check(rd_data == 8'h3C, "R4 busy write ignored", int'(rd_data), 8'h3C);
    wr_stat(8'h00);
    check(st_ovr, "R4 overrun kept by zero write", int'(st_ovr), 1);
    wr_stat(8'h01);
    check(!st_ovr, "R4 overrun cleared by one write", int'(st_ovr), 0);
    rd_pulse();

    // R6: slave 8-bit transfer
    cfg_master = 1'b0; cfg_len_m1 = 3'd7; miso_sel = 3;
    wr_dat(8'hB2);
    repeat (10) @(negedge clk);
    check(!sck_o && !st_busy && rd_data == 8'hB2, "R6 slave preload only",
          {sck_o, st_busy, rd_data}, 10'h0B2);
    ss_n_i = 1'b0; repeat (8) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin slv_bit(8'h3D >> b, o); tx[b] = o; end
    repeat (8) @(negedge clk);
    check(st_done && rd_data == 8'h3D, "R6 slave receive", {st_done, rd_data}, 9'h13D);
    check(tx == 8'hB2, "R6 slave transmit bits", int'(tx), 8'hB2);
    ss_n_i = 1'b1; rd_pulse();

    // R10: slave 4-bit
    cfg_len_m1 = 3'd3;
    wr_dat(8'hB2);
    ss_n_i = 1'b0; repeat (8) @(negedge clk);
    tx = '0;
    for (int b = 3; b >= 0; b--) begin slv_bit(4'b1010 >> b, o); tx[b] = o; end
    repeat (8) @(negedge clk);
    check(st_done && rd_data == 8'h2A, "R10 slave 4-bit receive", {st_done, rd_data}, 9'h12A);
    check(tx[3:0] == 4'hB, "R10 slave 4-bit transmit", int'(tx[3:0]), 4'hB);
    ss_n_i = 1'b1; rd_pulse();

    // R7: abort mid-character, then a fresh character
    cfg_len_m1 = 3'd7;
    wr_dat(8'hFF);
    ss_n_i = 1'b0; repeat (8) @(negedge clk);
    for (int b = 0; b < 3; b++) slv_bit(1'b1, o);
    repeat (4) @(negedge clk);
    check(st_busy, "R7 busy mid-character", int'(st_busy), 1);
    ss_n_i = 1'b1; repeat (10) @(negedge clk);
    check(!st_done && !st_busy, "R7 abort without done", {st_done, st_busy}, 0);
    ss_n_i = 1'b0; repeat (8) @(negedge clk);
    for (int b = 7; b >= 3; b--) slv_bit(8'h96 >> b, o);
    repeat (8) @(negedge clk);
    check(!st_done, "R7 count restarted after abort", int'(st_done), 0);
    wr_dat(8'h00);
    check(st_ovr, "R4 slave overrun", int'(st_ovr), 1);
    for (int b = 2; b >= 0; b--) slv_bit(8'h96 >> b, o);
    repeat (8) @(negedge clk);
    check(st_done && rd_data == 8'h96, "R7 full character after abort",
          {st_done, rd_data}, 9'h196);
    ss_n_i = 1'b1; rd_pulse(); wr_stat(8'h01);

    // R8: standalone timer
    cfg_en = 1'b0; tmr_irq_en = 1'b1;
    wr_div(16'd5);
    measure_irq(gap); measure_irq(gap);
    check(gap == 5, "R8 timer period small", gap, 5);
    wr_div(16'h0103);
    measure_irq(gap); measure_irq(gap);
    check(gap == 259, "R8 timer period two-byte", gap, 259);
    tmr_irq_en = 1'b0; cnt = 0;
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (tmr_irq) cnt++; end
    check(cnt == 0, "R8 no irq when interrupt disabled", cnt, 0);
    cfg_en = 1'b1; tmr_irq_en = 1'b1; cnt = 0;
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (tmr_irq) cnt++; end
    check(cnt == 0, "R8 no irq when engine enabled", cnt, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule